// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block drives a buzzer pin with a pulse train made from a low-speed base tick. The base tick is an enable pulse at sixteen times the nominal 32.768 kHz low-speed clock rate, which is 524.288 kHz. Configuration inputs choose one of eight tones, one of fifteen duty steps in sixteenths of the tone period, the output polarity, and one of four sounding patterns:
- steady sound,
- a single timed burst,
- a short on/off cadence,
- a long cadence with a longer rest.

A one-cycle `start` pulse begins sounding. A one-cycle `stop` pulse, or the end of a single burst, returns the pin to its idle level.

Each tone period is cut into sixteen slots. A slot advances after a per-tone number of base ticks, and the pin is active for the first N slots. The generator holds tone, duty and polarity in shadow registers. While sounding, these load only when a tone period wraps, so no partial or glitched period reaches the pin.

Pattern timing is counted in base ticks with a parameter `UNIT_TICKS`. Its default is 32768 ticks, which is 62.5 ms.

Top module: `buzzer_gen`

## Requirements
- R1: After reset `buzz_out` is 0 and `running` is 0.
- R2: While stopped, `buzz_out` equals `invert` within two clock cycles of any change to `invert`.
- R3: `tone_sel` codes 0..7 give a slot length of 8, 16, 24, 32, 48, 64, 80 and 112 base ticks. A tone period is 16 slots. The slot position advances only on a cycle with `base_tick` high.
- R4: In each tone period the pin is active for `duty_sel` slots (1..15) starting at slot 0. A `duty_sel` of 0 behaves as 1.
- R5: The active level is 1 when `invert`=0 and 0 when `invert`=1. The inactive level is the opposite.
- R6: `mode_sel`=0 (steady) sounds without end until a stop.
- R7: `mode_sel`=1 (single) sounds for 2·UNIT_TICKS base ticks. Then `running` falls by itself and the pin goes idle.
- R8: `mode_sel`=2 repeats UNIT_TICKS ticks sounding and then UNIT_TICKS ticks silent.
- R9: `mode_sel`=3 repeats 2·UNIT_TICKS ticks sounding and then 6·UNIT_TICKS ticks silent.
- R10: A `stop` pulse clears `running` on the next edge, and the pin is idle one edge later. `stop` wins over a simultaneous `start`.
- R11: Changes to `duty_sel`, `tone_sel` or `invert` while sounding take effect at the next tone period boundary. The mode is captured at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Enable pulse at 16× the low-speed clock rate |
| start | input | 1 | One-cycle pulse that begins sounding |
| stop | input | 1 | One-cycle pulse that ends sounding |
| mode_sel | input | 2 | Sounding pattern: 0 steady, 1 single, 2 short cadence, 3 long cadence |
| tone_sel | input | 3 | Tone code 0 (highest pitch) to 7 (lowest) |
| duty_sel | input | 4 | Active slots per period, 1..15 (0 acts as 1) |
| invert | input | 1 | 1 selects the negative-logic output |
| buzz_out | output | 1 | Registered buzzer pin |
| running | output | 1 | High while sounding is in progress |

## Verification
The tone counter and the pattern counter reach the pin only as a count of active cycles. The bench therefore counts active cycles over windows that are whole multiples of the tone period or cadence. A wrong divider entry, a duty slot that is off by one, or a cadence window of the wrong length changes that count within the first window, which lasts a few thousand cycles. A stuck shadow register or mistimed boundary loading shows up within one tone period after a change made mid-period. A running flag that fails to fall shows up as a nonzero active count after the single burst should have ended.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

  typedef enum logic [1:0] {
    MODE_STEADY = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_SHORT  = 2'd2,
    MODE_LONG   = 2'd3
  } buzz_mode_e;

  localparam int SLOTS      = 16;
  localparam int SLOT_W     = 4;
  localparam int DIV_W      = 7;
  localparam int TONE_W     = 3;

  // base ticks per slot for each tone code
  function automatic logic [DIV_W-1:0] slot_len(input logic [TONE_W-1:0] code);
    logic [DIV_W-1:0] r;
    case (code)
      3'd0:    r = 7'd8;
      3'd1:    r = 7'd16;
      3'd2:    r = 7'd24;
      3'd3:    r = 7'd32;
      3'd4:    r = 7'd48;
      3'd5:    r = 7'd64;
      3'd6:    r = 7'd80;
      default: r = 7'd112;
    endcase
    return r;
  endfunction

  // sounding / silent lengths in units
  function automatic int on_units(input buzz_mode_e m);
    case (m)
      MODE_SINGLE: return 2;
      MODE_SHORT:  return 1;
      MODE_LONG:   return 2;
      default:     return 1;
    endcase
  endfunction

  function automatic int off_units(input buzz_mode_e m);
    case (m)
      MODE_SHORT: return 1;
      MODE_LONG:  return 6;
      default:    return 1;
    endcase
  endfunction

endpackage

// File: rtl/buzz_tone_div.sv
module buzz_tone_div
  import buzz_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int SW = SLOT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          base_tick,
  input  logic [DW-1:0] div_val,
  output logic [SW-1:0] slot,
  output logic          period_end
);
  localparam logic [SW-1:0] LAST_SLOT = {SW{1'b1}};

  logic [DW-1:0] div_cnt;
  logic          slot_step;

  assign slot_step  = base_tick && (div_cnt == div_val - 1'b1);
  assign period_end = slot_step && (slot == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_cnt <= '0;
      slot    <= '0;
    end else if (base_tick) begin
      if (slot_step) begin
        div_cnt <= '0;
        slot    <= slot + 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buzz_pattern_seq.sv
module buzz_pattern_seq
  import buzz_pkg::*;
#(
  parameter int UNIT_TICKS = 32768,
  localparam int CW = $clog2(8 * UNIT_TICKS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       run,
  input  logic       base_tick,
  input  buzz_mode_e mode,
  output logic       win_on,
  output logic       done
);
  logic [CW-1:0] win_cnt;
  logic [CW-1:0] win_len;
  logic          win_last;
  logic          timed;

  assign timed    = (mode != MODE_STEADY);
  assign win_len  = win_on ? CW'(on_units(mode) * UNIT_TICKS)
                           : CW'(off_units(mode) * UNIT_TICKS);
  assign win_last = run && timed && base_tick && (win_cnt == win_len - 1'b1);
  assign done     = win_last && (mode == MODE_SINGLE);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_cnt <= '0;
      win_on  <= 1'b1;
    end else if (run && timed && base_tick) begin
      if (win_last) begin
        win_cnt <= '0;
        if (mode != MODE_SINGLE) win_on <= ~win_on;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buzzer_gen.sv
module buzzer_gen
  import buzz_pkg::*;
#(
  parameter int UNIT_TICKS = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       base_tick,
  input  logic       start,
  input  logic       stop,
  input  logic [1:0] mode_sel,
  input  logic [2:0] tone_sel,
  input  logic [3:0] duty_sel,
  input  logic       invert,
  output logic       buzz_out,
  output logic       running
);
  buzz_mode_e          mode_q;
  logic [TONE_W-1:0]   tone_q;
  logic [SLOT_W-1:0]   duty_q;
  logic                pol_q;
  logic                launch;
  logic                shadow_ld;
  logic [SLOT_W-1:0]   slot;
  logic                period_end;
  logic                win_on;
  logic                burst_done;
  logic                active_c;

  assign launch    = start && !stop;
  assign shadow_ld = !running || period_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      mode_q  <= MODE_STEADY;
    end else begin
      if (stop)            running <= 1'b0;
      else if (start)      running <= 1'b1;
      else if (burst_done) running <= 1'b0;
      if (launch) mode_q <= buzz_mode_e'(mode_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_q <= '0;
      duty_q <= SLOT_W'(1);
      pol_q  <= 1'b0;
    end else if (shadow_ld) begin
      tone_q <= tone_sel;
      duty_q <= (duty_sel == '0) ? SLOT_W'(1) : duty_sel;
      pol_q  <= invert;
    end
  end

  buzz_tone_div #(.DW(DIV_W), .SW(SLOT_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .clr        (launch),
    .base_tick  (base_tick),
    .div_val    (slot_len(tone_q)),
    .slot       (slot),
    .period_end (period_end)
  );

  buzz_pattern_seq #(.UNIT_TICKS(UNIT_TICKS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .clr       (launch),
    .run       (running),
    .base_tick (base_tick),
    .mode      (mode_q),
    .win_on    (win_on),
    .done      (burst_done)
  );

  assign active_c = running && win_on && (slot < duty_q);

  always_ff @(posedge clk) begin
    if (rst) buzz_out <= 1'b0;
    else     buzz_out <= pol_q ^ active_c;
  end
endmodule

// File: rtl/buzzer_gen_chk.sv
module buzzer_gen_chk
  import buzz_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       base_tick,
  input logic       start,
  input logic       stop,
  input logic       invert,
  input logic       buzz_out,
  input logic       running,
  input buzz_mode_e mode_q,
  input logic [3:0] slot,
  input logic       launch
);
  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> !running);

  // R7
  self_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> ($past(stop) || mode_q == MODE_SINGLE));

  // R6
  steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && mode_q == MODE_STEADY && !stop && !start) |=> running);

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !$past(running) && !$past(running, 2) && !$past(rst)
     && !$past(rst, 2) && invert == $past(invert) && invert == $past(invert, 2))
    |-> buzz_out == invert);

  // R3
  slot_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(slot) |-> ($past(base_tick) || $past(launch)));
endmodule

bind buzzer_gen buzzer_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .base_tick (base_tick),
  .start     (start),
  .stop      (stop),
  .invert    (invert),
  .buzz_out  (buzz_out),
  .running   (running),
  .mode_q    (mode_q),
  .slot      (slot),
  .launch    (launch)
);

// File: tb/sim_buzzer_gen.sv
`timescale 1ns/1ps
module sim_buzzer_gen;
  localparam int UNIT = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_tick = 1'b1;
  logic       half_rate = 1'b0;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [2:0] tone_sel = 3'd0;
  logic [3:0] duty_sel = 4'd4;
  logic       invert = 1'b0;
  logic       buzz_out;
  logic       running;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  buzzer_gen #(.UNIT_TICKS(UNIT)) u0 (
    .clk(clk), .rst(rst), .base_tick(base_tick), .start(start), .stop(stop),
    .mode_sel(mode_sel), .tone_sel(tone_sel), .duty_sel(duty_sel),
    .invert(invert), .buzz_out(buzz_out), .running(running)
  );

  always #5 clk = ~clk;

  always @(negedge clk) base_tick <= half_rate ? ~base_tick : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_active(input int n, input logic pol, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (buzz_out != pol) ones = ones + 1;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out after reset", buzz_out, 0);
    chk("R1 running after reset", running, 0);
  endtask

  task automatic t_idle_pol();
    @(negedge clk); invert = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 idle follows invert=1", buzz_out, 1);
    invert = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 idle follows invert=0", buzz_out, 0);
  endtask

  task automatic t_steady(input logic [2:0] t, input logic [3:0] d, input logic pol,
                          input int eff, input string tag);
    int ones, div;
    int divs[8] = '{8, 16, 24, 32, 48, 64, 80, 112};
    div = divs[t];
    tone_sel = t; duty_sel = d; invert = pol; mode_sel = 2'd0;
    pulse_start();
    repeat (5) @(negedge clk);
    count_active(2 * 16 * div * (half_rate ? 2 : 1), pol, ones);
    chk(tag, ones, 2 * eff * div * (half_rate ? 2 : 1));
    pulse_stop();
    @(negedge clk);
    chk("R10 idle after stop", buzz_out, pol);
    chk("R10 running cleared", running, 0);
  endtask

  task automatic t_single();
    int ones;
    tone_sel = 3'd0; duty_sel = 4'd5; invert = 1'b0; mode_sel = 2'd1;
    pulse_start();
    count_active(3 * UNIT, 1'b0, ones);
    // 2*UNIT ticks = 8 periods of 128, 5 slots of 8 each
    chk("R7 single burst active cycles", ones, 8 * 5 * 8);
    chk("R7 running self-cleared", running, 0);
  endtask

  task automatic t_short();
    int ones;
    tone_sel = 3'd0; duty_sel = 4'd6; invert = 1'b0; mode_sel = 2'd2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    count_active(4 * UNIT, 1'b0, ones);
    chk("R8 short cadence active cycles", ones, 2 * 4 * 6 * 8);
    repeat (UNIT + UNIT / 2 - 1) @(negedge clk);
    chk("R8 silent half", buzz_out, 0);
    chk("R8 still running", running, 1);
    pulse_stop();
  endtask

  task automatic t_long();
    int ones;
    tone_sel = 3'd0; duty_sel = 4'd8; invert = 1'b0; mode_sel = 2'd3;
    pulse_start();
    count_active(8 * UNIT, 1'b0, ones);
    chk("R9 long cadence active cycles", ones, 8 * 8 * 8);
    count_active(2 * UNIT, 1'b0, ones);
    chk("R9 second burst", ones, 8 * 8 * 8);
    pulse_stop();
  endtask

  task automatic t_boundary();
    tone_sel = 3'd0; duty_sel = 4'd4; invert = 1'b0; mode_sel = 2'd0;
    pulse_start();
    repeat (3) @(negedge clk);
    while (buzz_out != 1'b0) @(negedge clk);
    while (buzz_out != 1'b1) @(negedge clk);
    repeat (40) @(negedge clk);
    duty_sel = 4'd12;
    repeat (10) @(negedge clk);
    chk("R11 old duty holds mid-period", buzz_out, 0);
    while (buzz_out != 1'b0) @(negedge clk);
    while (buzz_out != 1'b1) @(negedge clk);
    repeat (80) @(negedge clk);
    chk("R11 new duty after boundary", buzz_out, 1);
    pulse_stop();
  endtask

  task automatic t_stop_wins();
    mode_sel = 2'd0;
    @(negedge clk); start = 1'b1; stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    chk("R10 stop beats start", running, 0);
    @(negedge clk);
    chk("R10 pin idle", buzz_out, invert);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_pol();
    t_steady(3'd0, 4'd4, 1'b0, 4, "R4 duty 4 tone 0");
    t_steady(3'd7, 4'd15, 1'b0, 15, "R3 tone 7 duty 15");
    t_steady(3'd4, 4'd0, 1'b0, 1, "R4 duty 0 acts as 1");
    t_steady(3'd2, 4'd9, 1'b1, 9, "R5 inverted tone 2");
    t_steady(3'd6, 4'd3, 1'b0, 3, "R6 steady tone 6");
    half_rate = 1'b1;
    t_steady(3'd1, 4'd7, 1'b0, 7, "R3 half-rate tick");
    half_rate = 1'b0;
    invert = 1'b0;
    t_single();
    t_short();
    t_long();
    t_boundary();
    t_stop_wins();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule